// File: doc/BRIEF.md
# Configurable Registered Command Buffer with Parity Check

This block is a clocked address/command register that sits between a memory controller and a rank of DRAM devices. On every rising clock edge it captures a word of command and address lines and drives it out again from flops. A two-bit configuration input selects one of two layouts. In the wide layout every input lane is registered once. In the narrow layout only the low lanes are used, and each one is driven out twice, on an A copy and on a B copy. The narrow layout can act as either the first or the second device of a cascaded pair.

The controller sends one parity bit per word, one clock after the word itself. The block checks even parity over a fixed subset of the lanes; lanes that are not shared across the module are left out. It drives the running sum out on a partial-parity pin. In a pair, the second device takes the first device's partial-parity pin as its parity input, so that the second device judges the whole set of lanes. An active-low error flag reports a mismatch and holds for a minimum time. When both chip-select inputs are high, the data copies and the partial-parity pin keep their values to save power. The clock-enable, on-die-termination and chip-select lanes are always registered.

Top module: `cmd_reg_buf`

## Requirements
- R1: With cfg_i equal to 2'b00 or 2'b01 (wide layout), q_a_o takes d_i at each rising edge and q_b_o is zero.
- R2: With cfg_i[1] set (narrow layout), both q_a_o[13:0] and q_b_o take d_i[13:0] at each rising edge, and q_a_o[24:14] is zero.
- R3: While cs_n_i and csr_n_i are both high at a rising edge, q_a_o, q_b_o and ppo_o keep their previous values.
- R4: cke_o, odt_o and cs_n_o take cke_i, odt_i and cs_n_i at every rising edge, whatever the chip-select state.
- R5: Parity is even over the lanes d_i[k] for every k except k = 0, 3 and 6, restricted to k < 14 in the narrow layout. ppo_o takes the parity of those lanes of an earlier word XOR par_i. That word was captured one edge earlier, or two edges earlier when cfg_i is 2'b11 (second device).
- R6: In the wide layout and with cfg_i = 2'b11, a sum of one formed at an edge drives err_n_o low from the following edge; a sum of zero leaves it high.
- R7: Once err_n_o goes low it stays low for at least two clock cycles. It returns high when no new mismatch arrives.
- R8: With cfg_i = 2'b10 (first device), err_n_o stays high whatever the data and the parity.
- R9: While rst_ni is low, all registered outputs are low except err_n_o, which is high, regardless of the clock.
- R10: In a pair where the second device's par_i comes from the first device's ppo_o, the second device's err_n_o goes low three edges after the data if the lanes checked on both devices, together with the controller's parity bit, hold an odd number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 2 | Layout select: 00/01 wide, 10 first of pair, 11 second of pair |
| d_i | input | 25 | Command/address lanes |
| par_i | input | 1 | Parity bit, one clock after its word, or partial parity from the first device |
| cs_n_i | input | 1 | Chip select, active low; also registered out |
| csr_n_i | input | 1 | Second chip select, active low |
| cke_i | input | 1 | Clock-enable lane |
| odt_i | input | 1 | Termination-control lane |
| q_a_o | output | 25 | Registered lanes, A copy |
| q_b_o | output | 14 | Registered lanes, B copy (narrow layout) |
| cke_o | output | 1 | Registered clock enable |
| odt_o | output | 1 | Registered termination control |
| cs_n_o | output | 1 | Registered chip select |
| ppo_o | output | 1 | Partial parity for cascading |
| err_n_o | output | 1 | Parity error flag, active low |

## Verification
The bench builds two instances with the default 25-lane wide word, the 14-lane narrow word, a skip mask on lanes 0, 3 and 6 and a two-cycle error hold. At these values, single-lane words can show that the skipped lanes do not count, and that lanes 14 and up are both cleared and left out of the check in the narrow layout. A single mismatch can show the flag rise again exactly when the hold runs out. Chaining the two instances as first and second device checks the extra pipeline stage of the second device against the partial parity of the first.

// File: rtl/cmd_buf_pkg.sv
package cmd_buf_pkg;

  typedef enum logic [1:0] {
    CFG_WIDE     = 2'b00,
    CFG_WIDE_ALT = 2'b01,
    CFG_PAIR_1ST = 2'b10,
    CFG_PAIR_2ND = 2'b11
  } cfg_e;

  typedef struct packed {
    logic narrow;
    logic second;
    logic err_en;
  } mode_t;

  function automatic mode_t decode_cfg(input logic [1:0] cfg);
    mode_t m;
    m.narrow = cfg[1];
    m.second = (cfg == CFG_PAIR_2ND);
    m.err_en = (cfg != CFG_PAIR_1ST);
    return m;
  endfunction

endpackage

// File: rtl/cmd_buf_mode_dec.sv
module cmd_buf_mode_dec
  import cmd_buf_pkg::*;
#(
  parameter int unsigned            WIDE_W    = 25,
  parameter int unsigned            NARROW_W  = 14,
  parameter logic [WIDE_W-1:0]      SKIP_MASK = WIDE_W'('h49)
) (
  input  logic [1:0]        cfg_i,
  output mode_t             mode_o,
  output logic [WIDE_W-1:0] chk_mask_o
);

  localparam logic [WIDE_W-1:0] CHK_WIDE   = ~SKIP_MASK;
  localparam logic [WIDE_W-1:0] LOW_LANES  = {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [WIDE_W-1:0] CHK_NARROW = CHK_WIDE & LOW_LANES;

  always_comb begin
    mode_o     = decode_cfg(cfg_i);
    chk_mask_o = mode_o.narrow ? CHK_NARROW : CHK_WIDE;
  end

endmodule

// File: rtl/cmd_buf_lanes.sv
module cmd_buf_lanes #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                narrow_i,
  input  logic                hold_i,
  input  logic [WIDE_W-1:0]   d_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o
);

  for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
    if (i < NARROW_W) begin : g_dual
      logic a_q, b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          a_q <= 1'b0;
          b_q <= 1'b0;
        end else if (!hold_i) begin
          a_q <= d_i[i];
          b_q <= d_i[i] & narrow_i;
        end
      end
      assign q_a_o[i] = a_q;
      assign q_b_o[i] = b_q;
    end else begin : g_single
      logic a_q;
      // upper lanes are unused in the narrow layout
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      a_q <= 1'b0;
        else if (!hold_i) a_q <= d_i[i] & ~narrow_i;
      end
      assign q_a_o[i] = a_q;
    end
  end

endmodule

// File: rtl/cmd_buf_parity.sv
module cmd_buf_parity #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned ERR_HOLD = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDE_W-1:0] d_i,
  input  logic [WIDE_W-1:0] mask_i,
  input  logic              second_i,
  input  logic              err_en_i,
  input  logic              hold_i,
  input  logic              par_i,
  output logic              ppo_o,
  output logic              err_n_o
);

  localparam int unsigned HC_W = $clog2(ERR_HOLD + 1);

  logic            p1_q, p2_q, sum_q, ppo_q, err_n_q;
  logic [HC_W-1:0] hc_q;
  logic            word_par, sum;

  assign word_par = ^(d_i & mask_i);
  // second device waits one more edge for the partial parity of the first
  assign sum      = (second_i ? p2_q : p1_q) ^ par_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q    <= 1'b0;
      p2_q    <= 1'b0;
      sum_q   <= 1'b0;
      ppo_q   <= 1'b0;
      err_n_q <= 1'b1;
      hc_q    <= '0;
    end else begin
      p1_q  <= word_par;
      p2_q  <= p1_q;
      sum_q <= sum;
      if (!hold_i) ppo_q <= sum;
      if (err_en_i && sum_q) begin
        err_n_q <= 1'b0;
        hc_q    <= HC_W'(ERR_HOLD - 1);
      end else if (hc_q != '0) begin
        err_n_q <= 1'b0;
        hc_q    <= hc_q - 1'b1;
      end else begin
        err_n_q <= 1'b1;
      end
    end
  end

  assign ppo_o   = ppo_q;
  assign err_n_o = err_n_q;

endmodule

// File: rtl/cmd_reg_buf.sv
module cmd_reg_buf
  import cmd_buf_pkg::*;
#(
  parameter int unsigned       WIDE_W    = 25,
  parameter int unsigned       NARROW_W  = 14,
  parameter logic [WIDE_W-1:0] SKIP_MASK = WIDE_W'('h49),
  parameter int unsigned       ERR_HOLD  = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          cfg_i,
  input  logic [WIDE_W-1:0]   d_i,
  input  logic                par_i,
  input  logic                cs_n_i,
  input  logic                csr_n_i,
  input  logic                cke_i,
  input  logic                odt_i,
  output logic [WIDE_W-1:0]   q_a_o,
  output logic [NARROW_W-1:0] q_b_o,
  output logic                cke_o,
  output logic                odt_o,
  output logic                cs_n_o,
  output logic                ppo_o,
  output logic                err_n_o
);

  mode_t             mode;
  logic [WIDE_W-1:0] chk_mask;
  logic              standby;

  assign standby = cs_n_i & csr_n_i;

  cmd_buf_mode_dec #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W),
    .SKIP_MASK(SKIP_MASK)
  ) u_dec (
    .cfg_i     (cfg_i),
    .mode_o    (mode),
    .chk_mask_o(chk_mask)
  );

  cmd_buf_lanes #(
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W)
  ) u_lanes (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .narrow_i(mode.narrow),
    .hold_i  (standby),
    .d_i     (d_i),
    .q_a_o   (q_a_o),
    .q_b_o   (q_b_o)
  );

  cmd_buf_parity #(
    .WIDE_W  (WIDE_W),
    .ERR_HOLD(ERR_HOLD)
  ) u_par (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .d_i     (d_i),
    .mask_i  (chk_mask),
    .second_i(mode.second),
    .err_en_i(mode.err_en),
    .hold_i  (standby),
    .par_i   (par_i),
    .ppo_o   (ppo_o),
    .err_n_o (err_n_o)
  );

  // control lanes bypass the chip-select gating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_o  <= 1'b0;
      odt_o  <= 1'b0;
      cs_n_o <= 1'b0;
    end else begin
      cke_o  <= cke_i;
      odt_o  <= odt_i;
      cs_n_o <= cs_n_i;
    end
  end

endmodule

// File: rtl/cmd_reg_buf_chk.sv
module cmd_reg_buf_chk #(
  parameter int unsigned WIDE_W   = 25,
  parameter int unsigned NARROW_W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          cfg_i,
  input logic                cs_n_i,
  input logic                csr_n_i,
  input logic                cke_i,
  input logic                odt_i,
  input logic [WIDE_W-1:0]   q_a_o,
  input logic [NARROW_W-1:0] q_b_o,
  input logic                cke_o,
  input logic                odt_o,
  input logic                cs_n_o,
  input logic                ppo_o,
  input logic                err_n_o
);

  assert_standby_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_i && csr_n_i) |=> ($stable(q_a_o) && $stable(q_b_o) && $stable(ppo_o)));

  assert_ctl_follow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cke_o == $past(cke_i) && odt_o == $past(odt_i) && cs_n_o == $past(cs_n_i)));

  assert_err_min_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_n_o) |=> !err_n_o);

  assert_first_no_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i == 2'b10 && $past(cfg_i) == 2'b10) |=> err_n_o);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_state_R9: assert (q_a_o == '0 && q_b_o == '0 && ppo_o == 1'b0 &&
                                     err_n_o && !cke_o && !odt_o && !cs_n_o);
    end
  end

endmodule

bind cmd_reg_buf cmd_reg_buf_chk #(
  .WIDE_W  (WIDE_W),
  .NARROW_W(NARROW_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cfg_i  (cfg_i),
  .cs_n_i (cs_n_i),
  .csr_n_i(csr_n_i),
  .cke_i  (cke_i),
  .odt_i  (odt_i),
  .q_a_o  (q_a_o),
  .q_b_o  (q_b_o),
  .cke_o  (cke_o),
  .odt_o  (odt_o),
  .cs_n_o (cs_n_o),
  .ppo_o  (ppo_o),
  .err_n_o(err_n_o)
);

// File: tb/cmd_reg_buf_test.sv
`timescale 1ns/1ps

// behavioural expectation built from the requirements
module cmd_buf_ref (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg,
  input  logic [24:0] d,
  input  logic        par,
  input  logic        csn,
  input  logic        csrn,
  input  logic        cke,
  input  logic        odt,
  output logic [24:0] qa,
  output logic [13:0] qb,
  output logic        ckeo,
  output logic        odto,
  output logic        cso,
  output logic        ppo,
  output logic        errn
);
  logic pa, pb, pend;
  int   left;

  function automatic logic word_par(input logic [24:0] w, input logic narrow);
    logic [24:0] m = 25'h1FF_FFB6;           // lanes 0, 3, 6 skipped
    if (narrow) m = m & 25'h000_3FFF;
    return ^(w & m);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qa <= '0; qb <= '0; ckeo <= 0; odto <= 0; cso <= 0;
      ppo <= 0; errn <= 1; pa <= 0; pb <= 0; pend <= 0; left <= 0;
    end else begin
      logic s;
      if (!(csn && csrn)) begin
        qa <= cfg[1] ? {11'b0, d[13:0]} : d;
        qb <= cfg[1] ? d[13:0] : 14'b0;
      end
      ckeo <= cke; odto <= odt; cso <= csn;
      pa <= word_par(d, cfg[1]);
      pb <= pa;
      s = ((cfg == 2'b11) ? pb : pa) ^ par;
      if (!(csn && csrn)) ppo <= s;
      pend <= s;
      if (pend && cfg != 2'b10) begin errn <= 0; left <= 1; end
      else if (left > 0)        begin errn <= 0; left <= left - 1; end
      else                             errn <= 1;
    end
  end
endmodule

module cmd_reg_buf_test;
  logic        clk = 0, rst_n = 1;
  logic [1:0]  cfg = 2'b00;
  logic [24:0] d_a = '0, d_b = '0;
  logic        par = 0, csn = 0, csrn = 0, cke = 0, odt = 0;

  logic [24:0] qa, qa_b, e_qa, e_qa_b;
  logic [13:0] qb, qb_b, e_qb, e_qb_b;
  logic ckeo, odto, cso, ppo, errn, e_ckeo, e_odto, e_cso, e_ppo, e_errn;
  logic ckeo_b, odto_b, cso_b, ppo_b, errn_b;
  logic e_ckeo_b, e_odto_b, e_cso_b, e_ppo_b, e_errn_b;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cmd_reg_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .d_i(d_a), .par_i(par),
    .cs_n_i(csn), .csr_n_i(csrn), .cke_i(cke), .odt_i(odt),
    .q_a_o(qa), .q_b_o(qb), .cke_o(ckeo), .odt_o(odto), .cs_n_o(cso),
    .ppo_o(ppo), .err_n_o(errn));

  cmd_reg_buf uut_b (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(2'b11), .d_i(d_b), .par_i(ppo),
    .cs_n_i(csn), .csr_n_i(csrn), .cke_i(cke), .odt_i(odt),
    .q_a_o(qa_b), .q_b_o(qb_b), .cke_o(ckeo_b), .odt_o(odto_b), .cs_n_o(cso_b),
    .ppo_o(ppo_b), .err_n_o(errn_b));

  cmd_buf_ref ref_a (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .d(d_a), .par(par), .csn(csn), .csrn(csrn),
    .cke(cke), .odt(odt), .qa(e_qa), .qb(e_qb), .ckeo(e_ckeo), .odto(e_odto),
    .cso(e_cso), .ppo(e_ppo), .errn(e_errn));

  cmd_buf_ref ref_b (
    .clk(clk), .rst_n(rst_n), .cfg(2'b11), .d(d_b), .par(e_ppo), .csn(csn), .csrn(csrn),
    .cke(cke), .odt(odt), .qa(e_qa_b), .qb(e_qb_b), .ckeo(e_ckeo_b), .odto(e_odto_b),
    .cso(e_cso_b), .ppo(e_ppo_b), .errn(e_errn_b));

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    chk(req, "q_a", 64'(qa), 64'(e_qa));
    chk(req, "q_b", 64'(qb), 64'(e_qb));
    chk(req, "ctl", {ckeo, odto, cso}, {e_ckeo, e_odto, e_cso});
    chk(req, "ppo", 64'(ppo), 64'(e_ppo));
    chk(req, "err_n", 64'(errn), 64'(e_errn));
    chk(req, "pair q", {qa_b, qb_b, ppo_b}, {e_qa_b, e_qb_b, e_ppo_b});
    chk(req, "pair err_n", 64'(errn_b), 64'(e_errn_b));
  endtask

  task automatic flush();
    d_a = '0; d_b = '0; par = 0; csn = 0; csrn = 0;
    repeat (4) cyc();
  endtask

  task automatic t_reset();
    @(negedge clk);
    d_a = 25'h1AB_CDEF; cke = 1; odt = 1; csn = 1; csrn = 0; par = 1;
    cyc();
    rst_n = 0;
    #1;
    chk("R9", "q_a in reset", 64'(qa), 64'h0);
    chk("R9", "q_b in reset", 64'(qb), 64'h0);
    chk("R9", "ppo in reset", 64'(ppo), 64'h0);
    chk("R9", "err_n in reset", 64'(errn), 64'h1);
    chk("R9", "ctl in reset", {ckeo, odto, cso}, 3'b000);
    @(negedge clk);
    rst_n = 1;
    flush();
  endtask

  // one word, parity bit on the next edge, flag one edge later
  task automatic err_case(input logic [24:0] w, input logic p, input logic bad,
                          input string req);
    d_a = w; cyc();
    d_a = '0; par = p; cyc();
    chk("R5", "ppo sum", 64'(ppo), 64'(bad));
    chk(req, "err_n before", 64'(errn), 64'h1);
    par = 0; cyc();
    chk(req, "err_n after sum", 64'(errn), 64'(!bad));
    cyc();
    chk("R7", "err_n hold", 64'(errn), 64'(!bad));
    cyc();
    chk("R7", "err_n release", 64'(errn), 64'h1);
  endtask

  task automatic t_wide_err();
    cfg = 2'b00; flush();
    err_case(25'h000_0001, 1'b0, 1'b0, "R5");   // skipped lane 0
    err_case(25'h000_0048, 1'b0, 1'b0, "R5");   // skipped lanes 3 and 6
    err_case(25'h000_0002, 1'b0, 1'b1, "R6");
    err_case(25'h000_0002, 1'b1, 1'b0, "R6");
    err_case(25'h100_0000, 1'b0, 1'b1, "R6");   // top lane checked in wide layout
    cfg = 2'b01; flush();
    err_case(25'h000_0006, 1'b1, 1'b1, "R6");
  endtask

  task automatic t_random(input logic [1:0] c, input string req);
    cfg = c; flush();
    for (int i = 0; i < 60; i++) begin
      d_a = 25'($urandom); d_b = 25'($urandom); par = 1'($urandom);
      cke = 1'($urandom); odt = 1'($urandom);
      csn = ($urandom % 4) == 0; csrn = ($urandom % 3) == 0;
      cyc();
      check_all(req);
    end
    flush();
  endtask

  task automatic t_wide_capture();
    cfg = 2'b00; flush();
    d_a = 25'h155_5555; cyc();
    chk("R1", "q_a wide", 64'(qa), 64'h155_5555);
    chk("R1", "q_b wide", 64'(qb), 64'h0);
    flush();
  endtask

  task automatic t_first_dev();
    cfg = 2'b10; flush();
    d_a = 25'h1FF_C00A; cyc();
    chk("R2", "q_a narrow", 64'(qa), 64'h000_000A);
    chk("R2", "q_b narrow", 64'(qb), 64'h000A);
    d_a = '0; par = 0; cyc();            // lane 1 and 3 set: checked parity 1
    chk("R5", "first ppo", 64'(ppo), 64'h1);
    repeat (3) begin
      cyc();
      chk("R8", "first err_n", 64'(errn), 64'h1);
    end
    d_a = 25'h100_4000; cyc();           // lanes 14 and 24 ignored in narrow
    d_a = '0; cyc();
    chk("R5", "narrow upper lanes unchecked", 64'(ppo), 64'h0);
    flush();
  endtask

  task automatic t_second_dev();
    cfg = 2'b11; flush();
    d_a = 25'h000_0020; cyc();           // lane 5, parity 1
    d_a = '0; par = 0; cyc();
    chk("R5", "second ppo not yet", 64'(ppo), 64'h0);
    par = 0; cyc();
    chk("R5", "second ppo two edges", 64'(ppo), 64'h1);
    chk("R6", "second err_n before", 64'(errn), 64'h1);
    cyc();
    chk("R6", "second err_n low", 64'(errn), 64'h0);
    flush();
  endtask

  task automatic t_standby();
    cfg = 2'b00; flush();
    d_a = 25'h0AB_CDEF; par = 0; cyc();
    d_a = 25'h000_0002; par = 1; cyc();  // sum for previous word
    d_a = 25'h1FF_FFFF; par = 0; csn = 1; csrn = 1; cke = 1; odt = 1; cyc();
    chk("R3", "q_a held", 64'(qa), 64'h000_0002);
    chk("R3", "ppo held", 64'(ppo), 64'(^(25'h0AB_CDEF & 25'h1FF_FFB6) ^ 1'b1));
    chk("R4", "ctl in standby", {ckeo, odto, cso}, 3'b111);
    csrn = 0; cke = 0; cyc();
    chk("R3", "q_a resumes", 64'(qa), 64'h1FF_FFFF);
    chk("R4", "ctl resumes", {ckeo, odto, cso}, 3'b011);
    csn = 0; odt = 0; flush();
  endtask

  task automatic cascade_case(input logic [13:0] wa, input logic [13:0] wb,
                              input logic p, input logic bad);
    d_a = 25'(wa); d_b = 25'(wb); cyc();
    d_a = '0; d_b = '0; par = p; cyc();
    par = 0; cyc();
    chk("R10", "pair err_n before", 64'(errn_b), 64'h1);
    cyc();
    chk("R10", "pair err_n", 64'(errn_b), 64'(!bad));
    repeat (2) cyc();
  endtask

  task automatic t_cascade();
    cfg = 2'b10; flush();
    cascade_case(14'h0002, 14'h0004, 1'b0, 1'b0);
    cascade_case(14'h0002, 14'h0000, 1'b0, 1'b1);
    cascade_case(14'h0000, 14'h0100, 1'b1, 1'b0);
    cascade_case(14'h0049, 14'h0049, 1'b1, 1'b1);   // only skipped lanes set
    flush();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9", "err_n at reset", 64'(errn), 64'h1);
    chk("R9", "q_a at reset", 64'(qa), 64'h0);
    rst_n = 1;
    flush();
    t_wide_capture();
    t_wide_err();
    t_first_dev();
    t_second_dev();
    t_standby();
    t_cascade();
    t_random(2'b00, "R1");
    t_random(2'b01, "R1");
    t_random(2'b10, "R2");
    t_random(2'b11, "R5");
    t_reset();
    finish_run();
  end
endmodule